// File: doc/BRIEF.md
# Stall Controller for a Five-Stage Pipeline Without Bypass

This block decides, every cycle, whether an in-order integer pipeline with five stages may move forward. The stages are fetch, register read, execute, memory and write-back. The pipeline has no bypass paths, so a register value can be used only once it has been written back. A branch is resolved only at write-back, so the instruction after a branch cannot be fetched earlier than that.

The front end offers one predecoded instruction per cycle. That instruction carries two source register numbers, a destination register number, a write flag, a branch flag and a sequence tag. The controller keeps a small record of each instruction in flight. From these records it drives three signals:
- a fetch hold, which stops the offered instruction from being taken;
- a decode hold, which freezes the fetch and register-read stages;
- an execute bubble, which puts an empty slot into execute.

It also reports the tag of the instruction that is leaving write-back.

Top module: `pipe_interlock`

## Requirements
- R1: Reset is synchronous and active high. After reset all stages are empty, and `fetch_hold`, `decode_hold`, `ex_bubble` and `wb_valid` are 0. This holds even when reset arrives while a branch is in flight.
- R2: Suppose an instruction in register read has a source equal to the nonzero destination of a write-enabled instruction in execute, memory or write-back. Then `decode_hold`, `ex_bubble` and `fetch_hold` are 1 in that cycle, and an empty slot enters execute. The dependent instruction reads its registers only in the cycle after the producer's write-back, and so reaches write-back four cycles after the producer does.
- R3: Register number 0 never causes a stall, whether it is read or written.
- R4: A destination whose write flag is 0 never causes a stall.
- R5: While a branch is in fetch, register read or execute, no new instruction is taken. The next instruction is in fetch in the same cycle that the branch is in write-back. This holds whether the branch is taken or not.
- R6: During a stall, the fetch and register-read stages keep their contents. Every instruction leaves write-back exactly once, in program order.
- R7: Once an instruction enters execute, it moves through memory and write-back on the next two cycles without ever being held.
- R8: A branch that is waiting on a data dependence is held in register read, and fetch stays blocked for the whole wait. The next fetch still lines up with the branch's write-back.
- R9: Instructions with no dependence and no branch are taken on consecutive cycles and leave write-back on consecutive cycles. The first instruction offered after reset is in fetch in cycle 1 and in write-back in cycle 5, where cycle 0 is the first cycle with reset low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nx_valid | input | 1 | An instruction is offered for fetch |
| nx_src_a | input | REG_W | First source register of the offered instruction |
| nx_src_b | input | REG_W | Second source register of the offered instruction |
| nx_dst | input | REG_W | Destination register of the offered instruction |
| nx_we | input | 1 | Offered instruction writes its destination |
| nx_branch | input | 1 | Offered instruction is a branch |
| nx_tag | input | TAG_W | Sequence tag of the offered instruction |
| fetch_hold | output | 1 | Offered instruction is not taken this cycle |
| decode_hold | output | 1 | Fetch and register-read stages keep their contents |
| ex_bubble | output | 1 | An empty slot enters execute |
| wb_valid | output | 1 | A valid instruction is in write-back |
| wb_tag | output | TAG_W | Tag of the instruction in write-back |

## Verification
The hardest case to reach is two kinds of stall overlapping. In one, a branch waits in register read on a load that is still in flight, so the data stall and the fetch block hold at the same time. In the other, a dependent instruction sits in register read in the very cycle its producer is in write-back, which must cost one more cycle. Directed sequences build both cases: a load followed by a branch on the loaded register, and a producer placed exactly three instructions ahead of its consumer. Seeded random programs use only four registers, so dependences are dense. They also contain frequent branches and writes to register 0. Each program's fetch and write-back cycles are compared with a schedule the bench computes from the timing rules.

// File: rtl/pipe_interlock_pkg.sv
package pipe_interlock_pkg;

    localparam int unsigned REG_W  = 5;
    localparam int unsigned TAG_W  = 8;
    localparam int unsigned N_LATE = 3;
    localparam int unsigned ST_EX  = 0;
    localparam int unsigned ST_M   = 1;
    localparam int unsigned ST_WB  = 2;
    localparam int unsigned N_BR   = 3;

    typedef logic [REG_W-1:0] reg_id_t;
    typedef logic [TAG_W-1:0] tag_t;

    // Front record: instruction in fetch or register read
    typedef struct packed {
        logic    valid;
        reg_id_t src_a;
        reg_id_t src_b;
        reg_id_t dst;
        logic    we;
        logic    br;
        tag_t    tag;
    } early_t;

    // Back record: sources are no longer needed past register read
    typedef struct packed {
        logic    valid;
        reg_id_t dst;
        logic    we;
        logic    br;
        tag_t    tag;
    } late_t;

    // True when a live writer of dst would feed a read of src
    function automatic logic lands_in(input logic live, input reg_id_t dst, input reg_id_t src);
        return live && (dst != '0) && (dst == src);
    endfunction

endpackage

// File: rtl/pipe_interlock_raw.sv
module pipe_interlock_raw
    import pipe_interlock_pkg::*;
#(
    parameter int unsigned DEPTH = N_LATE
) (
    input  logic                        rd_valid,
    input  reg_id_t                     rd_src_a,
    input  reg_id_t                     rd_src_b,
    input  logic [DEPTH-1:0]            wr_live,
    input  logic [DEPTH-1:0][REG_W-1:0] wr_dst,
    output logic                        raw_stall
);
    logic [DEPTH-1:0] hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit[i] = lands_in(wr_live[i], wr_dst[i], rd_src_a)
                      | lands_in(wr_live[i], wr_dst[i], rd_src_b);
    end

    assign raw_stall = rd_valid && (hit != '0);

endmodule

// File: rtl/pipe_interlock_fetch.sv
module pipe_interlock_fetch
    import pipe_interlock_pkg::*;
#(
    parameter int unsigned DEPTH = N_BR
) (
    input  logic [DEPTH-1:0] br_pend,
    input  logic             raw_stall,
    input  logic             nx_valid,
    output logic             fetch_hold,
    output logic             take
);
    logic ctrl_block;

    // A branch in fetch, register read or execute blocks the next fetch;
    // once it reaches memory the successor may enter fetch alongside its write-back.
    assign ctrl_block = |br_pend;
    assign fetch_hold = raw_stall | ctrl_block;
    assign take       = nx_valid & ~fetch_hold;

endmodule

// File: rtl/pipe_interlock_stages.sv
module pipe_interlock_stages
    import pipe_interlock_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  early_t                   nx_slot,
    input  logic                     take,
    input  logic                     hold,
    output early_t                   if_q,
    output early_t                   rf_q,
    output late_t [N_LATE-1:0]       late_q
);
    late_t rf_view;

    always_comb begin
        rf_view.valid = rf_q.valid;
        rf_view.dst   = rf_q.dst;
        rf_view.we    = rf_q.we;
        rf_view.br    = rf_q.br;
        rf_view.tag   = rf_q.tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            if_q <= '0;
            rf_q <= '0;
        end else if (!hold) begin
            rf_q <= if_q;
            if_q <= take ? nx_slot : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            late_q <= '0;
        end else begin
            late_q[ST_EX] <= hold ? '0 : rf_view;
            for (int i = 1; i < N_LATE; i++) begin
                late_q[i] <= late_q[i-1];
            end
        end
    end

    AST_HOLD_FREEZES_FRONT: assert property (@(posedge clk) disable iff (rst)
        hold |=> (rf_q == $past(rf_q)) && (if_q == $past(if_q))); // R6

    AST_HOLD_BUBBLES_EX: assert property (@(posedge clk) disable iff (rst)
        hold |=> !late_q[ST_EX].valid); // R2

    for (genvar i = 1; i < N_LATE; i++) begin : g_shift_chk
        AST_LATE_SHIFT: assert property (@(posedge clk) disable iff (rst)
            late_q[i-1].valid |=> (late_q[i] == $past(late_q[i-1]))); // R7
    end

endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
    import pipe_interlock_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             nx_valid,
    input  logic [REG_W-1:0] nx_src_a,
    input  logic [REG_W-1:0] nx_src_b,
    input  logic [REG_W-1:0] nx_dst,
    input  logic             nx_we,
    input  logic             nx_branch,
    input  logic [TAG_W-1:0] nx_tag,
    output logic             fetch_hold,
    output logic             decode_hold,
    output logic             ex_bubble,
    output logic             wb_valid,
    output logic [TAG_W-1:0] wb_tag
);
    early_t                      nx_slot;
    early_t                      if_q;
    early_t                      rf_q;
    late_t  [N_LATE-1:0]         late_q;
    logic                        raw_stall;
    logic                        take;
    logic   [N_LATE-1:0]         wr_live;
    logic   [N_LATE-1:0][REG_W-1:0] wr_dst;
    logic   [N_BR-1:0]           br_pend;
    logic                        unused_fields;

    always_comb begin
        nx_slot.valid = nx_valid;
        nx_slot.src_a = nx_src_a;
        nx_slot.src_b = nx_src_b;
        nx_slot.dst   = nx_dst;
        nx_slot.we    = nx_we;
        nx_slot.br    = nx_branch;
        nx_slot.tag   = nx_tag;
    end

    for (genvar i = 0; i < N_LATE; i++) begin : g_wr
        assign wr_live[i] = late_q[i].valid & late_q[i].we;
        assign wr_dst[i]  = late_q[i].dst;
    end

    assign br_pend = {late_q[ST_EX].valid & late_q[ST_EX].br,
                      rf_q.valid & rf_q.br,
                      if_q.valid & if_q.br};

    pipe_interlock_raw #(.DEPTH(N_LATE)) u_raw (
        .rd_valid  (rf_q.valid),
        .rd_src_a  (rf_q.src_a),
        .rd_src_b  (rf_q.src_b),
        .wr_live   (wr_live),
        .wr_dst    (wr_dst),
        .raw_stall (raw_stall)
    );

    pipe_interlock_fetch #(.DEPTH(N_BR)) u_fetch (
        .br_pend    (br_pend),
        .raw_stall  (raw_stall),
        .nx_valid   (nx_valid),
        .fetch_hold (fetch_hold),
        .take       (take)
    );

    pipe_interlock_stages u_stages (
        .clk     (clk),
        .rst     (rst),
        .nx_slot (nx_slot),
        .take    (take),
        .hold    (raw_stall),
        .if_q    (if_q),
        .rf_q    (rf_q),
        .late_q  (late_q)
    );

    assign decode_hold = raw_stall;
    assign ex_bubble   = raw_stall;
    assign wb_valid    = late_q[ST_WB].valid;
    assign wb_tag      = late_q[ST_WB].tag;

    assign unused_fields = ^{if_q.src_a, if_q.src_b, if_q.dst, if_q.we, if_q.tag,
                             rf_q.dst, rf_q.we, rf_q.tag,
                             late_q[ST_EX].tag, late_q[ST_M].tag,
                             late_q[ST_M].br, late_q[ST_WB].br};

    AST_ZERO_SRC_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (rf_q.valid && rf_q.src_a == '0 && rf_q.src_b == '0) |-> !decode_hold); // R3

    AST_NO_WRITER_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (rf_q.valid && wr_live == '0) |-> !decode_hold); // R4

    AST_BRANCH_EX_EMPTIES_IF: assert property (@(posedge clk) disable iff (rst)
        (late_q[ST_EX].valid && late_q[ST_EX].br) |=> !if_q.valid); // R5

    AST_STALL_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (rst)
        decode_hold |-> fetch_hold); // R8

endmodule

// File: tb/pipe_interlock_tb_top.sv
module pipe_interlock_tb_top;
    import pipe_interlock_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAXN = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [REG_W-1:0] p_sa  [MAXN];
    logic [REG_W-1:0] p_sb  [MAXN];
    logic [REG_W-1:0] p_dst [MAXN];
    logic             p_we  [MAXN];
    logic             p_br  [MAXN];
    int exp_if [MAXN];
    int exp_wb [MAXN];
    int got_if [MAXN];
    int got_wb [MAXN];
    int prog_n = 0;
    int idx = 0;
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int bubbles = 0;

    logic             nx_valid;
    logic [REG_W-1:0] nx_src_a, nx_src_b, nx_dst;
    logic             nx_we, nx_branch;
    logic [TAG_W-1:0] nx_tag;
    logic             fetch_hold, decode_hold, ex_bubble, wb_valid;
    logic [TAG_W-1:0] wb_tag;

    assign nx_valid  = (idx < prog_n);
    assign nx_src_a  = p_sa[idx];
    assign nx_src_b  = p_sb[idx];
    assign nx_dst    = p_dst[idx];
    assign nx_we     = p_we[idx];
    assign nx_branch = p_br[idx];
    assign nx_tag    = TAG_W'(idx);

    pipe_interlock dut_i (
        .clk(clk), .rst(rst), .nx_valid(nx_valid), .nx_src_a(nx_src_a),
        .nx_src_b(nx_src_b), .nx_dst(nx_dst), .nx_we(nx_we), .nx_branch(nx_branch),
        .nx_tag(nx_tag), .fetch_hold(fetch_hold), .decode_hold(decode_hold),
        .ex_bubble(ex_bubble), .wb_valid(wb_valid), .wb_tag(wb_tag)
    );

    task automatic check(input string req, input string what, input int got, input int expv);
        n_chk++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Schedule from the timing rules: fetch, register read, read cycle, write-back
    task automatic build_sched(input int n);
        int rfe [MAXN];
        int rd  [MAXN];
        for (int k = 0; k < n; k++) begin
            if (k == 0) exp_if[k] = 1;
            else begin
                exp_if[k] = imax(exp_if[k-1] + 1, rfe[k-1]);
                if (p_br[k-1]) exp_if[k] = imax(exp_if[k], exp_wb[k-1]);
            end
            rfe[k] = exp_if[k] + 1;
            if (k > 0) rfe[k] = imax(rfe[k], rd[k-1] + 1);
            rd[k] = rfe[k];
            for (int j = 0; j < k; j++) begin
                if (p_we[j] && p_dst[j] != 0 && (p_dst[j] == p_sa[k] || p_dst[j] == p_sb[k]))
                    rd[k] = imax(rd[k], exp_wb[j] + 1);
            end
            exp_wb[k] = rd[k] + 3;
        end
    endtask

    task automatic set_ins(input int k, input int sa, input int sb, input int d, input bit we, input bit br);
        p_sa[k] = REG_W'(sa); p_sb[k] = REG_W'(sb); p_dst[k] = REG_W'(d);
        p_we[k] = we; p_br[k] = br;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
    endtask

    // Runs the loaded program; compares with exp_if/exp_wb
    task automatic run_prog(input string req, input int n);
        int retired;
        int guard;
        bit acc;
        retired = 0; guard = 0; bubbles = 0;
        for (int k = 0; k < MAXN; k++) begin got_if[k] = -1; got_wb[k] = -1; end
        idx = 0;
        prog_n = 0;
        do_reset();
        prog_n = n;
        #1;
        while (retired < n && guard < 3000) begin
            if (wb_valid) begin
                check(req, "retire order", int'(wb_tag), retired);
                if (int'(wb_tag) < MAXN) got_wb[wb_tag] = cyc;
                retired++;
            end
            if (ex_bubble) bubbles++;
            acc = nx_valid && !fetch_hold;
            if (acc) got_if[idx] = cyc + 1;
            @(posedge clk);
            cyc++;
            #1;
            if (acc) idx++;
            @(negedge clk);
            guard++;
        end
        if (guard >= 3000) check(req, "run finished", 0, 1);
        for (int k = 0; k < n; k++) begin
            check(req, $sformatf("fetch cycle of %0d", k), got_if[k], exp_if[k]);
            check(req, $sformatf("write-back cycle of %0d", k), got_wb[k], exp_wb[k]);
        end
        prog_n = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd5821));
        for (int k = 0; k < MAXN; k++) set_ins(k, 0, 0, 0, 1'b0, 1'b0);

        // R1: reset state
        do_reset();
        #1;
        check("R1", "fetch_hold after reset", fetch_hold, 0);
        check("R1", "decode_hold after reset", decode_hold, 0);
        check("R1", "ex_bubble after reset", ex_bubble, 0);
        check("R1", "wb_valid after reset", wb_valid, 0);

        // R1/R5: reset while a branch is in flight
        set_ins(0, 0, 0, 0, 1'b0, 1'b1);
        set_ins(1, 0, 0, 1, 1'b1, 1'b0);
        idx = 0; prog_n = 2;
        @(posedge clk); #1; idx = 1;          // branch taken in cycle 0
        @(posedge clk); @(negedge clk);        // cycle 2: branch in register read
        check("R5", "fetch_hold with branch in register read", fetch_hold, 1);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "fetch_hold after mid-run reset", fetch_hold, 0);
        check("R1", "wb_valid after mid-run reset", wb_valid, 0);
        prog_n = 0; idx = 0;

        // R2/R5/R8: load, branch on loaded value, then a load whose address was just written
        set_ins(0, 4, 0, 9, 1'b1, 1'b0);
        set_ins(1, 9, 0, 0, 1'b0, 1'b1);
        set_ins(2, 4, 0, 4, 1'b1, 1'b0);
        set_ins(3, 9, 11, 9, 1'b1, 1'b0);
        set_ins(4, 9, 0, 9, 1'b1, 1'b0);
        set_ins(5, 2, 9, 2, 1'b1, 1'b0);
        exp_if[0] = 1;  exp_wb[0] = 5;
        exp_if[1] = 2;  exp_wb[1] = 9;
        exp_if[2] = 9;  exp_wb[2] = 13;
        exp_if[3] = 10; exp_wb[3] = 14;
        exp_if[4] = 11; exp_wb[4] = 18;
        exp_if[5] = 12; exp_wb[5] = 22;
        run_prog("R8", 6);
        check("R2", "execute bubbles in dependent sequence", bubbles, 9);

        // R2: consumer in register read while producer is in write-back waits one cycle
        set_ins(0, 6, 7, 1, 1'b1, 1'b0);
        set_ins(1, 6, 7, 2, 1'b1, 1'b0);
        set_ins(2, 6, 7, 3, 1'b1, 1'b0);
        set_ins(3, 1, 0, 4, 1'b1, 1'b0);
        exp_if[0] = 1; exp_if[1] = 2; exp_if[2] = 3; exp_if[3] = 4;
        exp_wb[0] = 5; exp_wb[1] = 6; exp_wb[2] = 7; exp_wb[3] = 9;
        run_prog("R2", 4);

        // R3: register 0 written then read
        set_ins(0, 1, 0, 0, 1'b1, 1'b0);
        set_ins(1, 0, 0, 2, 1'b1, 1'b0);
        set_ins(2, 0, 0, 0, 1'b1, 1'b0);
        exp_if[0] = 1; exp_if[1] = 2; exp_if[2] = 3;
        exp_wb[0] = 5; exp_wb[1] = 6; exp_wb[2] = 7;
        run_prog("R3", 3);

        // R4: destination without write flag is no hazard
        set_ins(0, 5, 6, 3, 1'b0, 1'b0);
        set_ins(1, 3, 3, 1, 1'b1, 1'b0);
        exp_if[0] = 1; exp_if[1] = 2;
        exp_wb[0] = 5; exp_wb[1] = 6;
        run_prog("R4", 2);

        // R9: independent stream
        for (int k = 0; k < 5; k++) begin
            set_ins(k, 6, 7, k + 1, 1'b1, 1'b0);
            exp_if[k] = 1 + k;
            exp_wb[k] = 5 + k;
        end
        run_prog("R9", 5);

        // R5: back-to-back branches
        set_ins(0, 0, 0, 0, 1'b0, 1'b1);
        set_ins(1, 0, 0, 0, 1'b0, 1'b1);
        set_ins(2, 6, 7, 1, 1'b1, 1'b0);
        exp_if[0] = 1; exp_if[1] = 5; exp_if[2] = 9;
        exp_wb[0] = 5; exp_wb[1] = 9; exp_wb[2] = 13;
        run_prog("R5", 3);

        // R6/R7: seeded random programs over four registers
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < 24; k++) begin
                set_ins(k, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                        ($urandom_range(0, 3) != 0), ($urandom_range(0, 5) == 0));
            end
            build_sched(24);
            run_prog("R6", 24);
        end

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule